// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of receive statistics for a small set of ports. At the end of each received frame the receive path presents one event: the port index, the frame length in bytes, the FCS-error flag, the destination MAC address, whether an IP header was found, whether that header is IPv6, and the leading byte of the destination IP address. In the cycle of the event, the counters for that port are updated. They cover the packet count, the octet count, a seven-bin length histogram, split runt and oversize counts, and L2 and L3 multicast and broadcast counts.

Software or a management engine reads one counter at a time through a simple read port. It places a port and a counter select, and the value comes back one cycle later. When the clear flag is raised with the read, the counter that was read restarts from zero. All counters saturate at all ones and do not wrap.

Top module: `rx_port_stats`

## Requirements
- R1: Each event with `evt_valid` high adds one to the packet counter (select 0) of port `evt_port` only. No counter of any other port changes.
- R2: The octet counter (select 1) adds `evt_len`, which includes the FCS bytes.
- R3: Exactly one histogram bin counts each frame, chosen by length: select 2 for exactly 64, 3 for 65..127, 4 for 128..255, 5 for 256..511, 6 for 512..1023, 7 for 1024..1518, 8 for 1519 and above. A frame shorter than 64 bytes counts in no bin.
- R4: A frame shorter than MIN_LEN (64) counts as a runt. It goes to select 9 when `evt_fcs_err` is low and to select 10 when it is high.
- R5: A frame longer than MAX_LEN (1518) counts as oversize. It goes to select 11 when `evt_fcs_err` is low and to select 12 when it is high.
- R6: A frame whose 48 `evt_dmac` bits are all ones counts as L2 broadcast (select 14). A frame with bit 40 set (the LSB of the first MAC byte, held in bits 47:40) that is not broadcast counts as L2 multicast (select 13).
- R7: With `evt_ip_valid` high, a frame counts as L3 multicast (select 15) in two cases. For IPv4 (`evt_ip_v6` low) the top nibble of `evt_dip_top` must be 0xE. For IPv6 the byte must be 0xFF. With `evt_ip_valid` low, neither L3 counter changes.
- R8: An IPv4 frame whose `evt_dip_top` is 0xFF counts as L3 broadcast (select 16). IPv6 frames never count as L3 broadcast.
- R9: When `rd_en` is high in a cycle, `rd_valid` is high in the next cycle. In that cycle `rd_data` holds the value the selected counter had before that cycle's update. A select of 17 or above, or a port index of NPORTS or above, returns zero. `rd_valid` is low after any cycle without `rd_en`.
- R10: A read with `rd_clr` high leaves the counter holding zero. If the same counter takes an increment in that cycle, it holds that increment alone. A read with `rd_clr` low does not change the counter.
- R11: Every counter saturates at 2^CNT_W-1 and never wraps.
- R12: Reset sets every counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | End-of-frame event strobe |
| evt_port | input | PORT_W | Port index of the frame |
| evt_len | input | LEN_W | Frame length in bytes, FCS included |
| evt_fcs_err | input | 1 | Frame had an FCS error |
| evt_dmac | input | 48 | Destination MAC; the first byte is in bits 47:40 |
| evt_ip_valid | input | 1 | An IP header was recognised |
| evt_ip_v6 | input | 1 | IP header is IPv6 (otherwise IPv4) |
| evt_dip_top | input | 8 | Most significant byte of the destination IP |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter select, 0..16 |
| rd_clr | input | 1 | Clear the counter that is read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | CNT_W | Counter value |

## Verification
The assertions assume that `evt_port` and `rd_port` name an existing port whenever their strobes are high. They also assume that events arrive at most one per cycle, and that the select and clear inputs are stable only during the cycle they are sampled. The random stimulus draws ports within range, and it draws lengths from bands that straddle every bin edge and both the runt and oversize limits. It also mixes all-ones, group-bit and plain MAC addresses with 0xE?, 0xFF and other IP leading bytes. A narrowed counter width lets the octet counters reach saturation within the run.

// File: rtl/rx_port_stats.sv
module rx_port_stats #(
  parameter int NPORTS  = 4,
  parameter int LEN_W   = 14,
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [PORT_W-1:0] evt_port,
  input  logic [LEN_W-1:0]  evt_len,
  input  logic              evt_fcs_err,
  input  logic [47:0]       evt_dmac,
  input  logic              evt_ip_valid,
  input  logic              evt_ip_v6,
  input  logic [7:0]        evt_dip_top,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [4:0]        rd_sel,
  input  logic              rd_clr,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NCNT = 17;
  localparam int C_PKT = 0, C_OCT = 1, C_H64 = 2, C_H127 = 3, C_H255 = 4, C_H511 = 5;
  localparam int C_H1023 = 6, C_H1518 = 7, C_HBIG = 8, C_RUNT = 9, C_RUNTF = 10;
  localparam int C_OVR = 11, C_OVRF = 12, C_L2MC = 13, C_L2BC = 14, C_L3MC = 15, C_L3BC = 16;

  logic [CNT_W-1:0] cnt     [NPORTS][NCNT];
  logic [CNT_W-1:0] cnt_nxt [NPORTS][NCNT];
  logic [NCNT-1:0]  hit;
  logic [CNT_W-1:0] rd_word;
  int unsigned      len_i;

  assign len_i = 32'(evt_len);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] d);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, d};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  wire l2_bc = &evt_dmac;
  wire v4    = evt_ip_valid & ~evt_ip_v6;
  wire v6    = evt_ip_valid & evt_ip_v6;
  wire runt  = len_i < MIN_LEN;
  wire ovr   = len_i > MAX_LEN;

  always_comb begin
    hit          = '0;
    hit[C_PKT]   = 1'b1;
    hit[C_OCT]   = 1'b1;
    hit[C_H64]   = len_i == 64;
    hit[C_H127]  = len_i >= 65   && len_i <= 127;
    hit[C_H255]  = len_i >= 128  && len_i <= 255;
    hit[C_H511]  = len_i >= 256  && len_i <= 511;
    hit[C_H1023] = len_i >= 512  && len_i <= 1023;
    hit[C_H1518] = len_i >= 1024 && len_i <= 1518;
    hit[C_HBIG]  = len_i >= 1519;
    hit[C_RUNT]  = runt & ~evt_fcs_err;
    hit[C_RUNTF] = runt & evt_fcs_err;
    hit[C_OVR]   = ovr & ~evt_fcs_err;
    hit[C_OVRF]  = ovr & evt_fcs_err;
    hit[C_L2BC]  = l2_bc;
    hit[C_L2MC]  = evt_dmac[40] & ~l2_bc;
    hit[C_L3MC]  = (v4 && evt_dip_top[7:4] == 4'hE) || (v6 && evt_dip_top == 8'hFF);
    hit[C_L3BC]  = v4 && evt_dip_top == 8'hFF;
  end

  always_comb begin
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] delta;
    for (int p = 0; p < NPORTS; p++) begin
      for (int c = 0; c < NCNT; c++) begin
        base  = (rd_en && rd_clr && rd_port == PORT_W'(p) && rd_sel == 5'(c)) ? '0 : cnt[p][c];
        delta = (c == C_OCT) ? CNT_W'(evt_len) : CNT_W'(1);
        cnt_nxt[p][c] = (evt_valid && evt_port == PORT_W'(p) && hit[c]) ? sat_add(base, delta) : base;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPORTS; p++)
      for (int c = 0; c < NCNT; c++)
        if (rd_port == PORT_W'(p) && rd_sel == 5'(c)) rd_word = cnt[p][c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++)
        for (int c = 0; c < NCNT; c++) cnt[p][c] <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++)
        for (int c = 0; c < NCNT; c++) cnt[p][c] <= cnt_nxt[p][c];
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_word : '0;
    end
  end

  wire clr00 = rd_en && rd_clr && rd_port == '0 && rd_sel == 5'd0;
  wire ev0   = evt_valid && evt_port == '0;

  // R1
  pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev0 && !clr00 && cnt[0][C_PKT] != '1 |=> cnt[0][C_PKT] == $past(cnt[0][C_PKT]) + 1'b1);
  // R11
  pkt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr00 |=> cnt[0][C_PKT] >= $past(cnt[0][C_PKT]));
  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr00 && !ev0 |=> cnt[0][C_PKT] == '0);
  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/rx_port_stats_tb.sv
module rx_port_stats_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int CW = 16;
  localparam int LW = 14;
  localparam int NC = 17;
  localparam longint MAXC = (64'd1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_fcs_err = 0, evt_ip_valid = 0, evt_ip_v6 = 0;
  logic [1:0] evt_port = 0, rd_port = 0;
  logic [LW-1:0] evt_len = 0;
  logic [47:0] evt_dmac = 0;
  logic [7:0] evt_dip_top = 0;
  logic rd_en = 0, rd_clr = 0;
  logic [4:0] rd_sel = 0;
  logic rd_valid;
  logic [CW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  longint model [NP][NC];

  rx_port_stats #(.NPORTS(NP), .LEN_W(LW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_port(evt_port), .evt_len(evt_len),
    .evt_fcs_err(evt_fcs_err), .evt_dmac(evt_dmac), .evt_ip_valid(evt_ip_valid),
    .evt_ip_v6(evt_ip_v6), .evt_dip_top(evt_dip_top), .rd_en(rd_en), .rd_port(rd_port),
    .rd_sel(rd_sel), .rd_clr(rd_clr), .rd_valid(rd_valid), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";  1: return "R2";
      2,3,4,5,6,7,8: return "R3";
      9,10: return "R4"; 11,12: return "R5";
      13,14: return "R6"; 15: return "R7"; 16: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit [NC-1:0] hits(int len, bit fcs, logic [47:0] mac, bit ipv, bit v6, logic [7:0] dip);
    bit [NC-1:0] h = '0;
    int bin;
    h[0] = 1; h[1] = 1;
    if (len < 64) bin = -1; else if (len == 64) bin = 2; else if (len < 128) bin = 3;
    else if (len < 256) bin = 4; else if (len < 512) bin = 5; else if (len < 1024) bin = 6;
    else if (len < 1519) bin = 7; else bin = 8;
    if (bin >= 0) h[bin] = 1;
    if (len < 64) h[fcs ? 10 : 9] = 1;
    if (len > 1518) h[fcs ? 12 : 11] = 1;
    if (mac == 48'hFFFF_FFFF_FFFF) h[14] = 1; else if (mac[40]) h[13] = 1;
    if (ipv && !v6) begin
      if (dip[7:4] == 4'hE) h[15] = 1;
      if (dip == 8'hFF) h[16] = 1;
    end
    if (ipv && v6 && dip == 8'hFF) h[15] = 1;
    return h;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit ev, int port, int len, bit fcs, logic [47:0] mac, bit ipv, bit v6,
                      logic [7:0] dip, bit rd, int rp, int rs, bit clr, string tag);
    longint exp_rd;
    bit [NC-1:0] h;
    evt_valid = ev; evt_port = 2'(port); evt_len = LW'(len); evt_fcs_err = fcs; evt_dmac = mac;
    evt_ip_valid = ipv; evt_ip_v6 = v6; evt_dip_top = dip;
    rd_en = rd; rd_port = 2'(rp); rd_sel = 5'(rs); rd_clr = clr;
    exp_rd = (rs < NC) ? model[rp][rs] : 0;
    if (rd && clr && rs < NC) model[rp][rs] = 0;
    if (ev) begin
      h = hits(len, fcs, mac, ipv, v6, dip);
      for (int c = 0; c < NC; c++)
        if (h[c]) begin
          model[port][c] += (c == 1) ? len : 1;
          if (model[port][c] > MAXC) model[port][c] = MAXC;
        end
    end
    @(negedge clk);
    if (rd) begin
      string t = (tag == "") ? tag_of(rs) : tag;
      check({t, " valid"}, rd_valid, 1);
      check(t, rd_data, exp_rd);
    end
    evt_valid = 0; rd_en = 0; rd_clr = 0;
  endtask

  task automatic ev_only(int port, int len, bit fcs, logic [47:0] mac, bit ipv, bit v6, logic [7:0] dip);
    step(1, port, len, fcs, mac, ipv, v6, dip, 0, 0, 0, 0, "");
  endtask

  task automatic rd_only(int rp, int rs, bit clr, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, rp, rs, clr, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) model[p][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < NC; s++) rd_only(2, s, 0, "R12");

    // directed corners
    ev_only(1, 63, 1, 48'h0, 0, 0, 8'h0);
    rd_only(1, 10, 0, "R4"); rd_only(1, 9, 0, "R4"); rd_only(1, 2, 0, "R3");
    ev_only(1, 64, 0, 48'h0, 0, 0, 8'h0);
    rd_only(1, 2, 0, "R3"); rd_only(1, 9, 0, "R4");
    ev_only(1, 1518, 0, 48'h0, 0, 0, 8'h0);
    ev_only(1, 1519, 1, 48'h0, 0, 0, 8'h0);
    rd_only(1, 7, 0, "R3"); rd_only(1, 8, 0, "R3"); rd_only(1, 12, 0, "R5"); rd_only(1, 11, 0, "R5");
    ev_only(2, 100, 0, 48'hFFFF_FFFF_FFFF, 1, 0, 8'hFF);
    ev_only(2, 100, 0, 48'h0100_0000_0000, 1, 1, 8'hFF);
    ev_only(2, 100, 0, 48'hFEFF_FFFF_FFFF, 1, 0, 8'hE1);
    ev_only(2, 100, 0, 48'h0, 0, 0, 8'hEE);
    rd_only(2, 14, 0, "R6"); rd_only(2, 13, 0, "R6");
    rd_only(2, 15, 0, "R7"); rd_only(2, 16, 0, "R8");
    rd_only(2, 20, 0, "R9");
    rd_only(0, 1, 0, "R1");
    // collision of clear and increment
    step(1, 1, 200, 0, 48'h0, 0, 0, 8'h0, 1, 1, 0, 1, "R10");
    rd_only(1, 0, 0, "R10"); rd_only(1, 0, 0, "R10");
    rd_only(1, 1, 1, "R10"); rd_only(1, 1, 0, "R10");
    // saturation of the octet counter
    for (int i = 0; i < 6; i++) ev_only(3, 16000, 0, 48'h0, 0, 0, 8'h0);
    rd_only(3, 1, 0, "R11");

    for (int i = 0; i < 4000; i++) begin
      int len, band;
      logic [47:0] mac;
      logic [7:0] dip;
      band = $urandom_range(0, 5);
      case (band)
        0: len = $urandom_range(20, 70);
        1: len = $urandom_range(120, 1100);
        2: len = $urandom_range(1500, 1540);
        3: len = $urandom_range(1, 16383);
        4: len = 64;
        default: len = $urandom_range(60, 2000);
      endcase
      mac = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: mac = 48'hFFFF_FFFF_FFFF;
        1: mac[40] = 1'b1;
        default: ;
      endcase
      dip = 8'($urandom);
      case ($urandom_range(0, 3))
        0: dip = 8'hFF;
        1: dip[7:4] = 4'hE;
        default: ;
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, NP-1), len, 1'($urandom), mac,
           1'($urandom), 1'($urandom), dip, $urandom_range(0, 2) == 0, $urandom_range(0, NP-1),
           $urandom_range(0, 18), $urandom_range(0, 5) == 0, "");
    end
    for (int p = 0; p < NP; p++) for (int s = 0; s < NC; s++) rd_only(p, s, 0, "");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule